// File: doc/BRIEF.md
# Marker-Based Serial Lane Word Aligner

This block recovers word boundaries on a serial lane whose bit sampling is already optimised but which carries no framing. It has two halves. The send side sits next to the sampling front end. When a bunch-crossing-zero pulse arrives, it replaces three sample words with a fixed idle marker: a word of zeros, a word of ones, then a word of zeros. The pulse is captured in the sample clock domain, so the marker keeps a fixed relation to the sample words.

The receive side takes W raw bits per bunch clock at an unknown bit offset. It keeps a sliding history of four words and tests all W offsets for the marker in parallel. It locks onto the first offset that matches and then delivers aligned W-bit words with a valid flag. While locked, it expects the marker once every ORBIT cycles at the stored offset, and it gives up after three missed markers in a row. W may be 8, 16 or 32.

Top module: `lane_word_aligner`

## Requirements
- R1: A high `bc0In` sampled at a clock edge makes `txWord` all zeros after that edge, all ones after the next edge and all zeros after the one after. From the fourth edge onwards `txWord` carries samples again. A `bc0In` that arrives during a marker restarts the marker.
- R2: Outside a marker, `txWord` equals the `sampleWord` sampled at the previous edge. Reset clears `txWord` to zero.
- R3: Bit order on `rxWord` is MSB first: bit W-1 is the earliest bit. The receiver finds the marker at every bit offset from 0 to W-1.
- R4: On the first accepted match, `locked`, `dataValid` and `bc0Seen` rise together, one edge after the history holds the final zero marker word. `dataOut` on that cycle is that zero word. The following `dataOut` words are the stream's next words, in order.
- R5: Reset drives `locked`, `dataValid`, `bc0Seen` and `dataOut` low. `dataValid` is low whenever `locked` is low.
- R6: A match is accepted only once four words have entered the history since reset. A marker made partly of history bits that were cleared at reset never locks.
- R7: While locked, the marker is checked exactly ORBIT cycles after the previous check at the stored offset. Each hit pulses `bc0Seen`. One or two misses in a row keep the lock, and a hit clears the miss count.
- R8: The third consecutive miss drops `locked` and `dataValid` on the same edge, 3*ORBIT cycles after the last `bc0Seen`. Search then resumes, and a later marker locks again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bunch clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleWord | input | W | Sample word from the front end |
| bc0In | input | 1 | Bunch-crossing-zero pulse, in the sample clock domain |
| txWord | output | W | Word sent on the lane, with the marker inserted |
| rxWord | input | W | Raw lane bits at an unknown offset, MSB earliest |
| dataOut | output | W | Aligned received word |
| dataValid | output | 1 | dataOut holds a valid aligned word |
| locked | output | 1 | Receiver holds a word offset |
| bc0Seen | output | 1 | Marker recognised; high while dataOut holds its final zero word |

## Verification
The send side is due one edge after each `bc0In` and `sampleWord`. The bench predicts `txWord` from its own model and compares it on every falling edge. On the receive side, `locked`, `dataValid` and `bc0Seen` follow one edge after the marker's last zero word enters the history. Later `bc0Seen` pulses must be exactly ORBIT cycles apart, and lock loss is due exactly 3*ORBIT cycles after the last `bc0Seen`; the bench measures both gaps with its own cycle counter. Sample words encode their cycle number, so every aligned word can be decoded and checked against the cycle arithmetic for all eight bit offsets.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;
  localparam int MARK_WORDS = 3;
  localparam int FILL_WORDS = 4;
  localparam int MISS_LIMIT = 3;

  typedef struct packed {
    logic wordValid;
    logic markerSeen;
  } alignStrobe_t;
endpackage

// File: rtl/bc0_marker_insert.sv
module bc0_marker_insert #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bc0In,
  input  logic [W-1:0] sampleWord,
  output logic [W-1:0] txWord
);
  // phase counts the marker words still to send after the first zero word
  logic [1:0] phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= 2'd0;
      txWord <= '0;
    end else if (bc0In) begin
      txWord <= '0;
      phase  <= 2'd2;
    end else if (phase == 2'd2) begin
      txWord <= {W{1'b1}};
      phase  <= 2'd1;
    end else if (phase == 2'd1) begin
      txWord <= '0;
      phase  <= 2'd0;
    end else begin
      txWord <= sampleWord;
    end
  end

  // R1: first marker word
  a_r1_first_zero: assert property (@(posedge clk) disable iff (rst)
    bc0In |=> (txWord == '0));
  // R1: middle marker word
  a_r1_ones: assert property (@(posedge clk) disable iff (rst)
    bc0In ##1 !bc0In |=> (txWord == {W{1'b1}}));
  // R1: last marker word
  a_r1_last_zero: assert property (@(posedge clk) disable iff (rst)
    bc0In ##1 !bc0In ##1 !bc0In |=> (txWord == '0));
  // R2: pass-through outside a marker
  a_r2_pass: assert property (@(posedge clk) disable iff (rst)
    (!bc0In && phase == 2'd0) |=> (txWord == $past(sampleWord)));
endmodule

// File: rtl/align_datapath.sv
module align_datapath
  import lane_align_pkg::*;
#(
  parameter int W     = 16,
  parameter int OFF_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [W-1:0]       rxWord,
  input  alignStrobe_t       strb,
  input  logic [OFF_W-1:0]   selOff,
  output logic [W-1:0]       matchVec,
  output logic [W-1:0]       dataOut,
  output logic               dataValid,
  output logic               bc0Seen
);
  localparam int HIST = FILL_WORDS * W;
  localparam int MW   = MARK_WORDS * W;
  localparam logic [MW-1:0] MARKER = {{W{1'b0}}, {W{1'b1}}, {W{1'b0}}};

  logic [HIST-1:0] hist;

  always_ff @(posedge clk) begin
    if (rst) hist <= '0;
    else     hist <= {hist[HIST-W-1:0], rxWord};
  end

  // one comparator per candidate bit offset
  for (genvar k = 0; k < W; k++) begin : g_off
    assign matchVec[k] = (hist[k +: MW] == MARKER);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dataOut   <= '0;
      dataValid <= 1'b0;
      bc0Seen   <= 1'b0;
    end else begin
      dataOut   <= hist[selOff +: W];
      dataValid <= strb.wordValid;
      bc0Seen   <= strb.markerSeen;
    end
  end

  // R5: marker flag only accompanies valid words
  a_r5_seen_valid: assert property (@(posedge clk) disable iff (rst)
    bc0Seen |-> dataValid);
  // R4: flagged word is the final zero marker word
  a_r4_seen_zero: assert property (@(posedge clk) disable iff (rst)
    bc0Seen |-> (dataOut == '0));
endmodule

// File: rtl/align_control.sv
module align_control
  import lane_align_pkg::*;
#(
  parameter int W     = 16,
  parameter int ORBIT = 3564,
  parameter int OFF_W = 4,
  parameter int ORB_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     matchVec,
  output alignStrobe_t     strb,
  output logic [OFF_W-1:0] selOff,
  output logic             lockedQ
);
  logic [2:0]       fillCnt;
  logic [OFF_W-1:0] storedOff;
  logic [OFF_W-1:0] foundOff;
  logic [ORB_W-1:0] orbitCnt;
  logic [1:0]       missCnt;
  logic             fillDone, searchHit, checkSlot, checkHit, dropLock;

  // lowest matching offset wins
  always_comb begin
    foundOff = '0;
    for (int k = W - 1; k >= 0; k--)
      if (matchVec[k]) foundOff = OFF_W'(k);
  end

  assign fillDone  = (fillCnt == 3'(FILL_WORDS));
  assign searchHit = !lockedQ && fillDone && (|matchVec);
  assign checkSlot = lockedQ && (orbitCnt == ORB_W'(ORBIT - 1));
  assign checkHit  = checkSlot && matchVec[storedOff];
  assign dropLock  = checkSlot && !matchVec[storedOff] &&
                     (missCnt == 2'(MISS_LIMIT - 1));

  always_comb begin
    strb.wordValid  = searchHit || (lockedQ && !dropLock);
    strb.markerSeen = searchHit || checkHit;
    selOff          = searchHit ? foundOff : storedOff;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt   <= '0;
      lockedQ   <= 1'b0;
      storedOff <= '0;
      orbitCnt  <= '0;
      missCnt   <= '0;
    end else begin
      if (!fillDone) fillCnt <= fillCnt + 3'd1;
      if (searchHit) begin
        lockedQ   <= 1'b1;
        storedOff <= foundOff;
        orbitCnt  <= '0;
        missCnt   <= '0;
      end else if (lockedQ) begin
        orbitCnt <= checkSlot ? '0 : orbitCnt + ORB_W'(1);
        if (checkSlot) begin
          if (checkHit)      missCnt <= '0;
          else if (dropLock) lockedQ <= 1'b0;
          else               missCnt <= missCnt + 2'd1;
        end
      end
    end
  end

  // R8: miss count never reaches the limit while locked
  a_r8_miss_bound: assert property (@(posedge clk) disable iff (rst)
    missCnt < 2'(MISS_LIMIT));
  // R8: third miss unlocks
  a_r8_drop: assert property (@(posedge clk) disable iff (rst)
    dropLock |=> !lockedQ);
  // R6: lock only after the history is filled
  a_r6_fill_first: assert property (@(posedge clk) disable iff (rst)
    $rose(lockedQ) |-> $past(fillDone));
  // R7: offset held while locked
  a_r7_offset_hold: assert property (@(posedge clk) disable iff (rst)
    lockedQ |=> $stable(storedOff));
  // R5: valid words only come with a lock
  a_r5_valid_lock: assert property (@(posedge clk) disable iff (rst)
    strb.wordValid |=> lockedQ);
endmodule

// File: rtl/lane_word_aligner.sv
module lane_word_aligner
  import lane_align_pkg::*;
#(
  parameter int W     = 16,
  parameter int ORBIT = 3564
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sampleWord,
  input  logic         bc0In,
  output logic [W-1:0] txWord,
  input  logic [W-1:0] rxWord,
  output logic [W-1:0] dataOut,
  output logic         dataValid,
  output logic         locked,
  output logic         bc0Seen
);
  localparam int OFF_W = (W > 1) ? $clog2(W) : 1;
  localparam int ORB_W = (ORBIT > 2) ? $clog2(ORBIT) : 1;

  alignStrobe_t     strb;
  logic [OFF_W-1:0] selOff;
  logic [W-1:0]     matchVec;

  bc0_marker_insert #(.W(W)) u_insert (
    .clk(clk), .rst(rst), .bc0In(bc0In),
    .sampleWord(sampleWord), .txWord(txWord)
  );

  align_datapath #(.W(W), .OFF_W(OFF_W)) u_path (
    .clk(clk), .rst(rst), .rxWord(rxWord), .strb(strb), .selOff(selOff),
    .matchVec(matchVec), .dataOut(dataOut), .dataValid(dataValid),
    .bc0Seen(bc0Seen)
  );

  align_control #(.W(W), .ORBIT(ORBIT), .OFF_W(OFF_W), .ORB_W(ORB_W)) u_ctrl (
    .clk(clk), .rst(rst), .matchVec(matchVec), .strb(strb),
    .selOff(selOff), .lockedQ(locked)
  );
endmodule

// File: tb/lane_word_aligner_bench.sv
`timescale 1ns/1ps
module lane_word_aligner_bench;
  localparam int BW = 8;
  localparam int ORB = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [BW-1:0] sampleWord = '0, rxWord = '0;
  logic bc0In = 1'b0;
  logic [BW-1:0] txWord, dataOut;
  logic dataValid, locked, bc0Seen;

  lane_word_aligner #(.W(BW), .ORBIT(ORB)) u_lane_word_aligner (
    .clk(clk), .rst(rst), .sampleWord(sampleWord), .bc0In(bc0In),
    .txWord(txWord), .rxWord(rxWord), .dataOut(dataOut),
    .dataValid(dataValid), .locked(locked), .bc0Seen(bc0Seen)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  int cyc, shift, bc0Last, skipCyc;
  bit bc0En, direct, checkCont, checkPeriod;
  logic [BW-1:0] mTx, mTxPrev;
  int mPhase;
  bit mMark;
  int prevKind, prevD, lastSeen, seenCount, fallCyc;
  bit wasLocked, everLocked, dropAfterLock;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] enc(input int n);
    logic [4:0] v = 5'(n);
    return {1'b0, v[4], v[3], v[2], 1'b0, v[1], v[0], 1'b1};
  endfunction

  function automatic int dec(input logic [BW-1:0] w);
    return int'({w[6], w[5], w[4], w[2], w[1]});
  endfunction

  task automatic doReset();
    rst = 1'b1; bc0In = 1'b0; rxWord = '0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0;
    mTx = '0; mTxPrev = '0; mPhase = 0; mMark = 0; cyc = 0;
    prevKind = 0; prevD = 0; lastSeen = 0; seenCount = 0; fallCyc = -1;
    wasLocked = 0; everLocked = 0; dropAfterLock = 0;
  endtask

  task automatic step();
    logic [2*BW-1:0] cat;
    logic [BW-1:0] nxt;
    bit b;
    // send side against own model
    chk(txWord == mTx, mMark ? "R1 marker word" : "R2 sample word", txWord, mTx);
    // receive side observations
    if (!locked) chk(!dataValid, "R5 valid while unlocked", dataValid, 0);
    if (locked) begin
      wasLocked = 1; everLocked = 1;
    end else if (wasLocked) begin
      if (fallCyc < 0) fallCyc = cyc;
      dropAfterLock = 1; wasLocked = 0;
    end
    if (bc0Seen) begin
      chk(dataOut == '0, "R4 seen word zero", dataOut, 0);
      if (checkPeriod && seenCount > 0)
        chk(cyc - lastSeen == ORB, "R7 marker period", cyc - lastSeen, ORB);
      lastSeen = cyc; seenCount++;
      prevKind = 2;
    end else if (checkCont && dataValid && dataOut != '0 && dataOut != {BW{1'b1}}) begin
      if (prevKind == 2)
        chk(dec(dataOut) % ORB == 3, "R4 first word after marker", dec(dataOut) % ORB, 3);
      else if (prevKind == 1)
        chk(dec(dataOut) == (prevD + 1) % 32, "R4 word order", dec(dataOut), (prevD + 1) % 32);
      prevKind = 1; prevD = dec(dataOut);
    end else prevKind = 0;
    // drive next inputs
    cat = {mTxPrev, mTx};
    if (direct) rxWord = (cyc == 0) ? {BW{1'b1}} : (cyc == 1) ? '0 : enc(cyc);
    else        rxWord = cat[shift +: BW];
    b = bc0En && cyc > 0 && (cyc % ORB == 0) && cyc <= bc0Last && cyc != skipCyc;
    bc0In = b;
    sampleWord = enc(cyc);
    // model the next edge
    if (b)                begin nxt = '0;          mPhase = 2; mMark = 1; end
    else if (mPhase == 2) begin nxt = {BW{1'b1}};  mPhase = 1; mMark = 1; end
    else if (mPhase == 1) begin nxt = '0;          mPhase = 0; mMark = 1; end
    else                  begin nxt = sampleWord;  mMark = 0; end
    mTxPrev = mTx; mTx = nxt;
    cyc++;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bc0En = 0; direct = 0; checkCont = 0; checkPeriod = 0;
    shift = 0; bc0Last = 100000; skipCyc = -1;
    doReset();
    // reset state (R5, R2)
    chk(!locked, "R5 reset locked", locked, 0);
    chk(!dataValid, "R5 reset valid", dataValid, 0);
    chk(!bc0Seen, "R5 reset seen", bc0Seen, 0);
    chk(dataOut == '0, "R5 reset dataOut", dataOut, 0);
    chk(txWord == '0, "R2 reset txWord", txWord, 0);

    // R3: sweep every bit offset
    for (int s = 0; s < BW; s++) begin
      shift = s; bc0En = 1; checkCont = 1; checkPeriod = 1; direct = 0;
      bc0Last = 100000; skipCyc = -1;
      doReset();
      while (cyc < 96) step();
      chk(seenCount == 5, "R3 markers found at offset", seenCount, 5);
      chk(locked && !dropAfterLock, "R3 lock held at offset", locked, 1);
    end

    // R6: marker formed with cleared history must not lock
    bc0En = 0; direct = 1; checkCont = 0; checkPeriod = 0;
    doReset();
    while (cyc < 24) step();
    chk(!everLocked, "R6 no lock across reset", everLocked, 0);
    direct = 0;

    // R7: one missed marker keeps the lock
    shift = 5; bc0En = 1; checkCont = 1; checkPeriod = 0; skipCyc = 48; bc0Last = 100000;
    doReset();
    while (cyc < 120) step();
    chk(seenCount == 6, "R7 hits around one miss", seenCount, 6);
    chk(locked && !dropAfterLock, "R7 lock kept after miss", locked, 1);

    // R8: three misses drop the lock, then relock
    shift = 2; skipCyc = -1; bc0Last = 16; checkCont = 0;
    doReset();
    while (cyc < 100) step();
    chk(fallCyc - lastSeen == 3 * ORB, "R8 lock loss timing", fallCyc - lastSeen, 3 * ORB);
    chk(!locked && !dataValid, "R8 unlocked and invalid", locked, 0);
    bc0Last = 100000;
    while (cyc < 160) step();
    chk(locked, "R8 relock after search", locked, 1);
    chk(seenCount >= 3, "R8 markers seen after relock", seenCount, 3);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule